// File: doc/BRIEF.md
# 18-bit Slot Instruction Boundary Decoder

This block receives one 256-bit code block in the short-slot layout: a 4-bit header, then fourteen 18-bit slots. It works out, for every slot, whether the slot opens an 18-bit instruction, opens an instruction of 32 bits or more, or carries continuation bits of an earlier instruction. Each slot marks its own role with a leading prefix, so every slot is classified at the same time and no decode field is needed.

A long instruction spans two slots by default. When its 4-bit length code reads 0 to 3, it spans 3 to 6 slots. The block checks that the header and every span are well formed. It also gives each slot a byte address that serves as a branch target: the address the slot would have if all fourteen slots were 16 bits wide and packed against the end of the block. All results are registered and appear one cycle after the block is presented.

Top module: `ssb_boundary_dec`

## Requirements
- R1: The header is the top 4 bits `blk_i[255:252]`. Any value other than 4'b0011 raises `fmt_err_o`.
- R2: Slot i occupies `blk_i[251-18*i -: 18]`, and its bit 17 is its first bit. A slot whose first bit is 0 sets `short_o[i]` and reports length 1 in `len_o[3*i +: 3]`.
- R3: A slot with prefix `10` (bits 17:16) sets `long_o[i]`. The length code is bits `[PSUPP_LSB+3:PSUPP_LSB]` of the 32-bit word {slot i[15:0], slot i+1[15:0]}; with the default of 20 these are slot i bits 7:4. A code of 4 or more gives length 2.
- R4: Length codes 0, 1, 2 and 3 give lengths of 3, 4, 5 and 6 slots respectively.
- R5: A slot with prefix `11` sets neither start flag and reports length 0. No slot sets both start flags.
- R6: If slot 0 has prefix `11`, `fmt_err_o` is raised.
- R7: If a long instruction needs slots beyond slot 13, `fmt_err_o` is raised.
- R8: If a slot that a long instruction covers does not have prefix `11`, `fmt_err_o` is raised.
- R9: A `11` slot that no instruction covers, after slot 0, is padding and does not raise `fmt_err_o`.
- R10: Slot i's address `addr_o[32*i +: 32]` is the input base with its low 5 bits replaced by 2*(2+i). Consecutive slots therefore differ by 2.
- R11: `out_valid` follows `in_valid` by one cycle. While `out_valid` is low, all flags and lengths are zero. Reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Block on `blk_i` is to be decoded |
| blk_i | input | 256 | Code block, header in the top bits |
| base_i | input | 32 | Byte address of the block |
| out_valid | output | 1 | Results below belong to a decoded block |
| short_o | output | 14 | Per-slot start of an 18-bit instruction |
| long_o | output | 14 | Per-slot start of a long instruction |
| len_o | output | 42 | Per-slot length in slots, 3 bits each |
| addr_o | output | 448 | Per-slot byte address, 32 bits each |
| fmt_err_o | output | 1 | Block is malformed |

## Verification
The bench builds the decoder with its default parameters: fourteen 18-bit slots, the length code at word bits 23:20, and 32-bit addresses. These values let directed blocks reach every length code, including a six-slot instruction and a long instruction that runs past slot 13. Hand-packed blocks cover padding slots, a broken span, a bad header and a continuation in slot 0. Address checks use a base with nonzero low bits, which shows that the in-block offset is replaced rather than added.

// File: rtl/ssb_pkg.sv
// Shared types for the short-slot boundary decoder.
// Assumes slots carry a two-bit role prefix in their top bits.
package ssb_pkg;
    localparam int MAX_SPAN = 6;
    localparam int LEN_W    = $clog2(MAX_SPAN + 1);

    typedef enum logic [1:0] {
        ROLE_SHORT = 2'd0,
        ROLE_HEAD  = 2'd1,
        ROLE_CONT  = 2'd2
    } slot_role_e;
endpackage

// File: rtl/ssb_classify.sv
// Maps a slot's two leading bits to its role.
// Assumes bit 1 of pfx is the slot's first bit.
module ssb_classify
    import ssb_pkg::*;
(
    input  logic [1:0]  pfx,
    output slot_role_e  role
);
    // Decode prefix: 0x short, 10 head, 11 continuation.
    always_comb begin
        if (!pfx[1])     role = ROLE_SHORT;
        else if (!pfx[0]) role = ROLE_HEAD;
        else              role = ROLE_CONT;
    end
endmodule

// File: rtl/ssb_span.sv
// Length and span check for the long instruction that may start at slot IDX.
// Assumes the code input was sliced from the instruction's leading 32 bits.
module ssb_span
    import ssb_pkg::*;
#(
    parameter int SLOTS = 14,
    parameter int IDX   = 0
) (
    input  logic             is_head,
    input  logic [3:0]       code,
    input  logic [SLOTS-1:0] cont_v,
    output logic [LEN_W-1:0] len,
    output logic             err
);
    logic [SLOTS+MAX_SPAN-1:0] cont_x;
    logic [LEN_W-1:0]          span;

    // Zero-extend the continuation map so lookups past the block read as "not continuation".
    assign cont_x = {{MAX_SPAN{1'b0}}, cont_v};

    // Translate the length code into a span in slots.
    always_comb begin
        if (code < 4'd4) span = LEN_W'(code) + LEN_W'(3);
        else             span = LEN_W'(2);
    end

    // Flag a span that overruns the block or covers a non-continuation slot.
    always_comb begin
        err = 1'b0;
        len = '0;
        if (is_head) begin
            len = span;
            if (IDX + int'(span) > SLOTS) err = 1'b1;
            for (int k = 1; k < MAX_SPAN; k++) begin
                if (k < int'(span) && !cont_x[IDX+k]) err = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ssb_addr.sv
// Computes per-slot byte addresses as if slots were 16-bit and packed to the block end.
// Assumes the block size in bytes is a power of two.
module ssb_addr #(
    parameter int SLOTS     = 14,
    parameter int AW        = 32,
    parameter int BLK_BYTES = 32
) (
    input  logic [AW-1:0]       base,
    output logic [SLOTS*AW-1:0] addr
);
    localparam int OFF_BITS = $clog2(BLK_BYTES);
    localparam int FIRST_HW = BLK_BYTES / 2 - SLOTS;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Replace the in-block offset with this slot's halfword position.
        assign addr[i*AW +: AW] = {base[AW-1:OFF_BITS], OFF_BITS'((FIRST_HW + i) * 2)};
    end
endmodule

// File: rtl/ssb_boundary_dec.sv
// Short-slot code block boundary decoder (top).
// Classifies every slot in parallel, sizes long instructions from their
// length code, checks the block's form and registers all results once.
// Assumes the header sits in the top bits and slot 0 follows it directly.
module ssb_boundary_dec
    import ssb_pkg::*;
#(
    parameter int              SLOTS     = 14,
    parameter int              SLOT_W    = 18,
    parameter int              HDR_W     = 4,
    parameter logic [HDR_W-1:0] HDR_CODE = 4'b0011,
    parameter int              PSUPP_LSB = 20,
    parameter int              AW        = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [HDR_W+SLOTS*SLOT_W-1:0] blk_i,
    input  logic [AW-1:0]              base_i,
    output logic                       out_valid,
    output logic [SLOTS-1:0]           short_o,
    output logic [SLOTS-1:0]           long_o,
    output logic [SLOTS*LEN_W-1:0]     len_o,
    output logic [SLOTS*AW-1:0]        addr_o,
    output logic                       fmt_err_o
);
    localparam int BLK_W     = HDR_W + SLOTS * SLOT_W;
    localparam int HALF      = SLOT_W - 2;
    localparam int BLK_BYTES = BLK_W / 8;

    logic [HDR_W-1:0]       hdr;
    logic [SLOT_W-1:0]      slot    [SLOTS];
    slot_role_e             role    [SLOTS];
    logic [SLOTS-1:0]       is_short, is_head, is_cont, span_err;
    logic [SLOTS*LEN_W-1:0] len_n;
    logic [SLOTS*AW-1:0]    addr_n;
    logic                   err_n;

    assign hdr = blk_i[BLK_W-1 -: HDR_W];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [LEN_W-1:0]  head_len;
        logic [2*HALF-1:0] word;

        // Cut slot i out of the block, first slot just below the header.
        assign slot[i] = blk_i[BLK_W-HDR_W-1-i*SLOT_W -: SLOT_W];

        ssb_classify u_cls (
            .pfx  (slot[i][SLOT_W-1 -: 2]),
            .role (role[i])
        );

        assign is_short[i] = (role[i] == ROLE_SHORT);
        assign is_head[i]  = (role[i] == ROLE_HEAD);
        assign is_cont[i]  = (role[i] == ROLE_CONT);

        // Leading 32 bits of a long instruction; the last slot has no successor.
        if (i < SLOTS - 1) begin : g_word
            assign word = {slot[i][HALF-1:0], slot[i+1][HALF-1:0]};
        end else begin : g_word_last
            assign word = {slot[i][HALF-1:0], {HALF{1'b0}}};
        end

        ssb_span #(.SLOTS(SLOTS), .IDX(i)) u_span (
            .is_head (is_head[i]),
            .code    (word[PSUPP_LSB +: 4]),
            .cont_v  (is_cont),
            .len     (head_len),
            .err     (span_err[i])
        );

        // Per-slot length: one for short, span for a head, zero for continuation.
        assign len_n[i*LEN_W +: LEN_W] = is_short[i] ? LEN_W'(1) : head_len;
    end

    ssb_addr #(.SLOTS(SLOTS), .AW(AW), .BLK_BYTES(BLK_BYTES)) u_addr (
        .base (base_i),
        .addr (addr_n)
    );

    // Block is malformed on a bad header, a leading continuation or a broken span.
    assign err_n = (hdr != HDR_CODE) || is_cont[0] || (|span_err);

    // Register every result; flags are cleared on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            short_o   <= '0;
            long_o    <= '0;
            len_o     <= '0;
            fmt_err_o <= 1'b0;
            addr_o    <= '0;
        end else begin
            out_valid <= in_valid;
            short_o   <= in_valid ? is_short : '0;
            long_o    <= in_valid ? is_head  : '0;
            len_o     <= in_valid ? len_n    : '0;
            fmt_err_o <= in_valid & err_n;
            addr_o    <= addr_n;
        end
    end
endmodule

// File: rtl/ssb_boundary_dec_chk.sv
// Property checker for ssb_boundary_dec, attached by bind.
// Assumes it sees the top's header bits plus slot 0's prefix on blk_hi.
module ssb_boundary_dec_chk
    import ssb_pkg::*;
#(
    parameter int               SLOTS    = 14,
    parameter int               HDR_W    = 4,
    parameter logic [HDR_W-1:0] HDR_CODE = 4'b0011,
    parameter int               AW       = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [HDR_W+1:0]       blk_hi,
    input logic                   out_valid,
    input logic [SLOTS-1:0]       short_o,
    input logic [SLOTS-1:0]       long_o,
    input logic [SLOTS*LEN_W-1:0] len_o,
    input logic [SLOTS*AW-1:0]    addr_o,
    input logic                   fmt_err_o
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (short_o == '0 && long_o == '0 && len_o == '0 && !fmt_err_o));
    a_r1_bad_header: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blk_hi[HDR_W+1 -: HDR_W] != HDR_CODE) |=> fmt_err_o);
    a_r6_first_cont: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blk_hi[1:0] == 2'b11) |=> fmt_err_o);
    a_r7_last_long: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && long_o[SLOTS-1]) |-> fmt_err_o);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(short_o[i] && long_o[i]));
        a_r2_short_len: assert property (@(posedge clk) disable iff (!rst_n)
            short_o[i] |-> len_o[i*LEN_W +: LEN_W] == LEN_W'(1));
        a_r4_long_len: assert property (@(posedge clk) disable iff (!rst_n)
            long_o[i] |-> (len_o[i*LEN_W +: LEN_W] >= LEN_W'(2) &&
                           len_o[i*LEN_W +: LEN_W] <= LEN_W'(MAX_SPAN)));
        a_r5_cont_len: assert property (@(posedge clk) disable iff (!rst_n)
            (!short_o[i] && !long_o[i]) |-> len_o[i*LEN_W +: LEN_W] == '0);
        if (i < SLOTS - 1) begin : g_step
            a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> addr_o[(i+1)*AW +: AW] == addr_o[i*AW +: AW] + AW'(2));
        end
    end
endmodule

bind ssb_boundary_dec ssb_boundary_dec_chk #(
    .SLOTS(SLOTS), .HDR_W(HDR_W), .HDR_CODE(HDR_CODE), .AW(AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .blk_hi    (blk_i[HDR_W+SLOTS*SLOT_W-1 -: HDR_W+2]),
    .out_valid (out_valid),
    .short_o   (short_o),
    .long_o    (long_o),
    .len_o     (len_o),
    .addr_o    (addr_o),
    .fmt_err_o (fmt_err_o)
);

// File: tb/ssb_boundary_dec_tb.sv
`timescale 1ns/1ps
module ssb_boundary_dec_tb;
    localparam int SLOTS = 14;
    localparam int AW    = 32;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [255:0]         blk_i = '0;
    logic [AW-1:0]        base_i = '0;
    logic                 out_valid;
    logic [SLOTS-1:0]     short_o, long_o;
    logic [SLOTS*3-1:0]   len_o;
    logic [SLOTS*AW-1:0]  addr_o;
    logic                 fmt_err_o;

    int total = 0;
    int bad   = 0;
    logic [17:0] sl [SLOTS];

    always #2 clk = ~clk;

    ssb_boundary_dec u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .blk_i(blk_i),
        .base_i(base_i), .out_valid(out_valid), .short_o(short_o),
        .long_o(long_o), .len_o(len_o), .addr_o(addr_o), .fmt_err_o(fmt_err_o)
    );

    function automatic logic [17:0] s_short(input logic [15:0] p);
        return {2'b01, p};
    endfunction
    // Long head with length code in slot bits 7:4 (word bits 23:20).
    function automatic logic [17:0] s_head(input logic [3:0] code);
        return {2'b10, 8'hA5, code, 4'h3};
    endfunction
    function automatic logic [17:0] s_cont(input logic [15:0] p);
        return {2'b11, p};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_short();
        for (int i = 0; i < SLOTS; i++) sl[i] = s_short(16'(i * 3 + 1));
    endtask

    // Pack header and slots, present for one cycle, return at the next falling edge.
    task automatic apply(input logic [3:0] hdr, input logic [AW-1:0] base);
        logic [255:0] b;
        b[255:252] = hdr;
        for (int i = 0; i < SLOTS; i++) b[251-18*i -: 18] = sl[i];
        @(negedge clk);
        blk_i = b; base_i = base; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [2:0] len_of(input int i);
        return len_o[i*3 +: 3];
    endfunction

    task automatic t_reset();
        chk("R11 reset valid", 64'(out_valid), 0);
        chk("R11 reset flags", 64'({short_o, long_o}), 0);
        chk("R11 reset err", 64'(fmt_err_o), 0);
    endtask

    task automatic t_all_short();
        fill_short();
        apply(4'b0011, 32'h0000_1000);
        chk("R11 valid", 64'(out_valid), 1);
        chk("R2 short mask", 64'(short_o), 64'h3FFF);
        chk("R2 long mask", 64'(long_o), 0);
        chk("R2 len slot 7", 64'(len_of(7)), 1);
        chk("R9 no err", 64'(fmt_err_o), 0);
    endtask

    task automatic t_lengths();
        sl[0] = s_head(4'hF); sl[1] = s_cont(16'h1111);
        sl[2] = s_head(4'h0); sl[3] = s_cont(0); sl[4] = s_cont(0);
        sl[5] = s_head(4'h1);
        for (int i = 6; i < 9; i++) sl[i] = s_cont(16'(i));
        sl[9] = s_head(4'h2);
        for (int i = 10; i < 14; i++) sl[i] = s_cont(16'(i));
        apply(4'b0011, 32'h0000_2000);
        chk("R3 long mask", 64'(long_o), 64'h0225);
        chk("R5 short mask", 64'(short_o), 0);
        chk("R3 len two", 64'(len_of(0)), 2);
        chk("R4 code0 len", 64'(len_of(2)), 3);
        chk("R4 code1 len", 64'(len_of(5)), 4);
        chk("R4 code2 len", 64'(len_of(9)), 5);
        chk("R5 cont len", 64'(len_of(13)), 0);
        chk("R4 no err", 64'(fmt_err_o), 0);
    endtask

    task automatic t_six();
        fill_short();
        sl[1] = s_head(4'h3);
        for (int i = 2; i < 7; i++) sl[i] = s_cont(16'hFFFF);
        apply(4'b0011, 32'h0000_3000);
        chk("R4 code3 len", 64'(len_of(1)), 6);
        chk("R2 short after span", 64'(short_o), 64'h3F81);
        chk("R4 six no err", 64'(fmt_err_o), 0);
    endtask

    task automatic t_padding();
        fill_short();
        sl[0] = s_head(4'h7); sl[1] = s_cont(0); sl[2] = s_cont(16'h5555);
        sl[10] = s_cont(0);
        apply(4'b0011, 32'h0000_4000);
        chk("R9 padding no err", 64'(fmt_err_o), 0);
        chk("R9 padding len", 64'(len_of(2)), 0);
        chk("R9 padding flags", 64'({short_o[10], long_o[10]}), 0);
    endtask

    task automatic t_overrun();
        fill_short();
        sl[11] = s_head(4'h1); sl[12] = s_cont(0); sl[13] = s_cont(0);
        apply(4'b0011, 32'h0000_5000);
        chk("R7 overrun err", 64'(fmt_err_o), 1);
        fill_short();
        sl[13] = s_head(4'hF);
        apply(4'b0011, 32'h0000_5000);
        chk("R7 last slot long err", 64'(fmt_err_o), 1);
        fill_short();
        sl[12] = s_head(4'hF); sl[13] = s_cont(0);
        apply(4'b0011, 32'h0000_5000);
        chk("R7 exact fit no err", 64'(fmt_err_o), 0);
    endtask

    task automatic t_bad_cover();
        fill_short();
        sl[0] = s_head(4'h0); sl[1] = s_cont(0);
        apply(4'b0011, 32'h0000_6000);
        chk("R8 broken span err", 64'(fmt_err_o), 1);
        chk("R8 slot2 still short", 64'(short_o[2]), 1);
    endtask

    task automatic t_first_cont();
        fill_short();
        sl[0] = s_cont(0);
        apply(4'b0011, 32'h0000_7000);
        chk("R6 first cont err", 64'(fmt_err_o), 1);
    endtask

    task automatic t_header();
        fill_short();
        apply(4'b0100, 32'h0000_8000);
        chk("R1 bad header err", 64'(fmt_err_o), 1);
        apply(4'b0011, 32'h0000_8000);
        chk("R1 good header no err", 64'(fmt_err_o), 0);
    endtask

    task automatic t_addr();
        fill_short();
        apply(4'b0011, 32'h1234_5677);
        chk("R10 addr slot0", 64'(addr_o[0 +: AW]), 64'h1234_5664);
        chk("R10 addr slot5", 64'(addr_o[5*AW +: AW]), 64'h1234_566E);
        chk("R10 addr slot13", 64'(addr_o[13*AW +: AW]), 64'h1234_567E);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R11 idle valid", 64'(out_valid), 0);
        chk("R11 idle flags", 64'({short_o, long_o, fmt_err_o}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_all_short();
        t_lengths();
        t_six();
        t_padding();
        t_overrun();
        t_bad_cover();
        t_first_cont();
        t_header();
        t_addr();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule